// File: doc/BRIEF.md
# Word/Byte Adder with Status Flags

This block is the addition datapath of a 16-bit execution unit. A caller presents a source value, a destination value, a width select (byte or word) and the incoming status word, then pulses an operation strobe. One clock later the block gives the raw sum, the value to write back to the destination, a two-bit byte-write-enable and an updated status word. The updated status word carries carry, zero, negative and overflow. The source can be the presented operand or a value taken from a small built-in constant table, so no operand fetch is needed for common increments.

In byte mode only the low eight bits of the source take part. Flags come from the 8-bit result. When the destination is a register, the result is zero-extended. When the destination is a memory word, a lane select (address bit 0) picks which byte of that word receives the result. The other byte keeps its old value, and the write-enable marks only the written lane. All status bits other than the four flags are copied from the incoming status word.

Top module: `addflag_unit`

## Requirements
- R1: While reset is held, and after it is released, every output is zero until the first strobed operation.
- R2: Outputs change only on the clock edge where `op_valid` is high and show that operation's result from the next cycle on. `res_valid` is high for exactly the cycle after each strobe, and all other outputs hold while the strobe is low.
- R3: In word mode, the sum is the 16-bit addition, carry (status bit 0) is the carry out of bit 15, and negative (status bit 2) copies bit 15 of the sum.
- R4: Overflow (status bit 8) is set only when both addends have the same sign bit and the result's sign bit differs from it. Bit 15 is the sign bit in word mode and bit 7 in byte mode.
- R5: Zero (status bit 1) is set whenever the result is zero, including when a carry is produced at the same time.
- R6: In byte mode, all four flags come from the 8-bit sum: carry from bit 7 and negative from bit 7. `sum_q` is the 8-bit result zero-extended.
- R7: In byte mode with a register destination (`dst_is_mem`=0), the addend is the low byte of `dst_operand`. The write-back value has its upper byte cleared, and `byte_we_q` is 2'b11.
- R8: In byte mode with a memory destination, `lane_hi`=0 adds to and replaces bits 7:0, with `byte_we_q`=2'b01. `lane_hi`=1 adds to and replaces bits 15:8, with `byte_we_q`=2'b10. The other byte of `wb_data_q` equals the same byte of `dst_operand`.
- R9: With `src_is_const`=1, `src_operand` is ignored and `const_code` selects the source: 0 gives 0, 1 gives +1, 2 gives +2, 3 gives +4, 4 gives +8, 5 gives all ones (0xFFFF in word mode, 0xFF in byte mode), and codes 6 and 7 give 0.
- R10: Status bits 3 to 7 and 9 to 15 of `status_q` equal the same bits of `status_in` at the strobe. The flag bits 0, 1, 2 and 8 are replaced whatever their incoming value.
- R11: In word mode, `wb_data_q` equals the sum and `byte_we_q` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe |
| byte_mode | input | 1 | 1 = byte operation, 0 = word |
| dst_is_mem | input | 1 | Destination is a memory word (lane merge) |
| lane_hi | input | 1 | Byte lane for memory destinations (address bit 0) |
| src_is_const | input | 1 | Take the source from the constant table |
| const_code | input | 3 | Constant table index |
| src_operand | input | 16 | Source value |
| dst_operand | input | 16 | Destination's current value |
| status_in | input | 16 | Incoming status word |
| sum_q | output | 16 | Raw sum (byte results zero-extended) |
| wb_data_q | output | 16 | Value to write to the destination |
| byte_we_q | output | 2 | Byte write enables for `wb_data_q` |
| status_q | output | 16 | Updated status word |
| res_valid | output | 1 | Result strobe, one cycle after `op_valid` |

## Verification
On every cycle, the bound checker enforces several relations. The outputs hold when no strobe arrives. Zero must agree with the sum, and negative with the sum's sign bit. Non-flag status bits must match the incoming word, and write-enable shapes and the preserved memory lane must match for each mode. Arithmetic correctness is left to the bench's scenarios: carry and overflow values, the constant table contents and the exact merged words. These need known operand pairs, including the sign-boundary and wrap-to-zero cases and both byte lanes.

// File: rtl/addflag_pkg.sv
package addflag_pkg;
   // Flag positions inside the status word
   localparam int ST_C = 0;
   localparam int ST_Z = 1;
   localparam int ST_N = 2;
   localparam int ST_V = 8;

   localparam int KSEL_W = 3;

   // Constant table indices
   localparam logic [KSEL_W-1:0] K_ZERO  = 3'd0;
   localparam logic [KSEL_W-1:0] K_ONE   = 3'd1;
   localparam logic [KSEL_W-1:0] K_TWO   = 3'd2;
   localparam logic [KSEL_W-1:0] K_FOUR  = 3'd3;
   localparam logic [KSEL_W-1:0] K_EIGHT = 3'd4;
   localparam logic [KSEL_W-1:0] K_ONES  = 3'd5;

   typedef struct packed {
      logic v;
      logic n;
      logic z;
      logic c;
   } flags_t;
endpackage

// File: rtl/addflag_src.sv
module addflag_src
   import addflag_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              src_is_const,
   input  logic [KSEL_W-1:0] const_code,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] src_operand,
   output logic [DATA_W-1:0] addend
);
   localparam int LANE_W = DATA_W / 2;
   localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};
   localparam logic [DATA_W-1:0] LANE_ONES = {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};

   logic [DATA_W-1:0] kval;

   always_comb begin
      unique case (const_code)
         K_ZERO:  kval = '0;
         K_ONE:   kval = DATA_W'(1);
         K_TWO:   kval = DATA_W'(2);
         K_FOUR:  kval = DATA_W'(4);
         K_EIGHT: kval = DATA_W'(8);
         K_ONES:  kval = byte_mode ? LANE_ONES : ALL_ONES;
         default: kval = '0;
      endcase
   end

   assign addend = src_is_const ? kval : src_operand;
endmodule

// File: rtl/addflag_core.sv
module addflag_core
   import addflag_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              byte_mode,
   input  logic              dst_is_mem,
   input  logic              lane_hi,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] sum_ext,
   output flags_t            flags
);
   localparam int LANE_W = DATA_W / 2;

   logic [DATA_W:0]   wsum;
   logic [LANE_W:0]   bsum;
   logic [LANE_W-1:0] b_lane;
   flags_t            wf, bf;

   // byte addend comes from the addressed lane only for memory targets
   assign b_lane = (dst_is_mem && lane_hi) ? b_in[DATA_W-1:LANE_W] : b_in[LANE_W-1:0];

   assign wsum = {1'b0, a_in} + {1'b0, b_in};
   assign bsum = {1'b0, a_in[LANE_W-1:0]} + {1'b0, b_lane};

   always_comb begin
      wf.c = wsum[DATA_W];
      wf.n = wsum[DATA_W-1];
      wf.z = (wsum[DATA_W-1:0] == '0);
      wf.v = (a_in[DATA_W-1] == b_in[DATA_W-1]) && (wsum[DATA_W-1] != a_in[DATA_W-1]);

      bf.c = bsum[LANE_W];
      bf.n = bsum[LANE_W-1];
      bf.z = (bsum[LANE_W-1:0] == '0);
      bf.v = (a_in[LANE_W-1] == b_lane[LANE_W-1]) && (bsum[LANE_W-1] != a_in[LANE_W-1]);
   end

   assign flags   = byte_mode ? bf : wf;
   assign sum_ext = byte_mode ? {{(DATA_W-LANE_W){1'b0}}, bsum[LANE_W-1:0]} : wsum[DATA_W-1:0];
endmodule

// File: rtl/addflag_merge.sv
module addflag_merge #(
   parameter int DATA_W = 16
) (
   input  logic              byte_mode,
   input  logic              dst_is_mem,
   input  logic              lane_hi,
   input  logic [DATA_W-1:0] sum_ext,
   input  logic [DATA_W-1:0] dst_operand,
   output logic [DATA_W-1:0] wb_data,
   output logic [1:0]        byte_we
);
   localparam int LANE_W = DATA_W / 2;
   localparam int LANES  = 2;

   logic lane_merge;
   assign lane_merge = byte_mode && dst_is_mem;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic LSEL = 1'(i);
      always_comb begin
         if (lane_merge) begin
            wb_data[i*LANE_W +: LANE_W] = (lane_hi == LSEL) ? sum_ext[LANE_W-1:0]
                                                            : dst_operand[i*LANE_W +: LANE_W];
            byte_we[i] = (lane_hi == LSEL);
         end else begin
            // word result, or zero-extended byte result for registers
            wb_data[i*LANE_W +: LANE_W] = sum_ext[i*LANE_W +: LANE_W];
            byte_we[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/addflag_unit.sv
module addflag_unit
   import addflag_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int STATUS_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic                byte_mode,
   input  logic                dst_is_mem,
   input  logic                lane_hi,
   input  logic                src_is_const,
   input  logic [KSEL_W-1:0]   const_code,
   input  logic [DATA_W-1:0]   src_operand,
   input  logic [DATA_W-1:0]   dst_operand,
   input  logic [STATUS_W-1:0] status_in,
   output logic [DATA_W-1:0]   sum_q,
   output logic [DATA_W-1:0]   wb_data_q,
   output logic [1:0]          byte_we_q,
   output logic [STATUS_W-1:0] status_q,
   output logic                res_valid
);
   if (DATA_W != 16) begin : g_bad_width
      $error("addflag_unit: DATA_W must be 16");
   end
   if (STATUS_W <= ST_V) begin : g_bad_status
      $error("addflag_unit: STATUS_W too narrow for the overflow bit");
   end

   logic [DATA_W-1:0]   addend;
   logic [DATA_W-1:0]   sum_ext;
   logic [DATA_W-1:0]   wb_next;
   logic [1:0]          we_next;
   flags_t              fl;
   logic [STATUS_W-1:0] st_next;

   addflag_src #(.DATA_W(DATA_W)) u_src (
      .src_is_const (src_is_const),
      .const_code   (const_code),
      .byte_mode    (byte_mode),
      .src_operand  (src_operand),
      .addend       (addend)
   );

   addflag_core #(.DATA_W(DATA_W)) u_core (
      .byte_mode  (byte_mode),
      .dst_is_mem (dst_is_mem),
      .lane_hi    (lane_hi),
      .a_in       (addend),
      .b_in       (dst_operand),
      .sum_ext    (sum_ext),
      .flags      (fl)
   );

   addflag_merge #(.DATA_W(DATA_W)) u_merge (
      .byte_mode   (byte_mode),
      .dst_is_mem  (dst_is_mem),
      .lane_hi     (lane_hi),
      .sum_ext     (sum_ext),
      .dst_operand (dst_operand),
      .wb_data     (wb_next),
      .byte_we     (we_next)
   );

   always_comb begin
      st_next       = status_in;
      st_next[ST_C] = fl.c;
      st_next[ST_Z] = fl.z;
      st_next[ST_N] = fl.n;
      st_next[ST_V] = fl.v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q     <= '0;
         wb_data_q <= '0;
         byte_we_q <= '0;
         status_q  <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= op_valid;
         if (op_valid) begin
            sum_q     <= sum_ext;
            wb_data_q <= wb_next;
            byte_we_q <= we_next;
            status_q  <= st_next;
         end
      end
   end
endmodule

// File: rtl/addflag_unit_chk.sv
module addflag_unit_chk
   import addflag_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int STATUS_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                op_valid,
   input logic                byte_mode,
   input logic                dst_is_mem,
   input logic                lane_hi,
   input logic [DATA_W-1:0]   dst_operand,
   input logic [STATUS_W-1:0] status_in,
   input logic [DATA_W-1:0]   sum_q,
   input logic [DATA_W-1:0]   wb_data_q,
   input logic [1:0]          byte_we_q,
   input logic [STATUS_W-1:0] status_q,
   input logic                res_valid
);
   localparam int LANE_W = DATA_W / 2;
   localparam logic [STATUS_W-1:0] KEEP_MASK =
      ~((STATUS_W'(1) << ST_C) | (STATUS_W'(1) << ST_Z) |
        (STATUS_W'(1) << ST_N) | (STATUS_W'(1) << ST_V));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(sum_q) && $stable(wb_data_q) && $stable(byte_we_q) &&
                     $stable(status_q) && !res_valid));

   p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);

   p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (status_q[ST_Z] == (sum_q == '0)));

   p_neg_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !byte_mode) |=> (status_q[ST_N] == sum_q[DATA_W-1]));

   p_neg_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && byte_mode) |=> (status_q[ST_N] == sum_q[LANE_W-1] &&
                                   sum_q[DATA_W-1:LANE_W] == '0));

   p_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && byte_mode && !dst_is_mem) |=>
         (wb_data_q[DATA_W-1:LANE_W] == '0 && byte_we_q == 2'b11));

   p_lane_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && byte_mode && dst_is_mem) |=>
         ($countones(byte_we_q) == 1 && byte_we_q[1] == $past(lane_hi)));

   p_lane_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && byte_mode && dst_is_mem) |=>
         ($past(lane_hi) ? (wb_data_q[LANE_W-1:0] == $past(dst_operand[LANE_W-1:0]))
                         : (wb_data_q[DATA_W-1:LANE_W] == $past(dst_operand[DATA_W-1:LANE_W]))));

   p_keep_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> ((status_q & KEEP_MASK) == ($past(status_in) & KEEP_MASK)));

   p_word_we_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !byte_mode) |=> (byte_we_q == 2'b11 && wb_data_q == sum_q));
endmodule

bind addflag_unit addflag_unit_chk #(.DATA_W(DATA_W), .STATUS_W(STATUS_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_valid    (op_valid),
   .byte_mode   (byte_mode),
   .dst_is_mem  (dst_is_mem),
   .lane_hi     (lane_hi),
   .dst_operand (dst_operand),
   .status_in   (status_in),
   .sum_q       (sum_q),
   .wb_data_q   (wb_data_q),
   .byte_we_q   (byte_we_q),
   .status_q    (status_q),
   .res_valid   (res_valid)
);

// File: tb/addflag_unit_tb.sv
module addflag_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        byte_mode = 1'b0;
   logic        dst_is_mem = 1'b0;
   logic        lane_hi = 1'b0;
   logic        src_is_const = 1'b0;
   logic [2:0]  const_code = '0;
   logic [15:0] src_operand = '0;
   logic [15:0] dst_operand = '0;
   logic [15:0] status_in = '0;
   logic [15:0] sum_q, wb_data_q, status_q;
   logic [1:0]  byte_we_q;
   logic        res_valid;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   addflag_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .byte_mode(byte_mode),
      .dst_is_mem(dst_is_mem), .lane_hi(lane_hi), .src_is_const(src_is_const),
      .const_code(const_code), .src_operand(src_operand), .dst_operand(dst_operand),
      .status_in(status_in), .sum_q(sum_q), .wb_data_q(wb_data_q),
      .byte_we_q(byte_we_q), .status_q(status_q), .res_valid(res_valid)
   );

   typedef struct packed {
      logic        bm;   // byte mode
      logic        mem;  // memory destination
      logic        hi;   // upper lane
      logic        kc;   // constant source
      logic [2:0]  k;
      logic [15:0] src;
      logic [15:0] dst;
      logic [15:0] wb;
      logic [1:0]  we;
      logic [3:0]  fl;   // {V,N,Z,C}
   } vec_t;

   localparam int NV = 19;
   localparam vec_t TBL [NV] = '{
      // word, register source: R3 R11
      '{1'b0,1'b0,1'b0,1'b0,3'd0,16'h1234,16'h4321,16'h5555,2'b11,4'b0000},
      '{1'b0,1'b0,1'b0,1'b0,3'd0,16'hFFFF,16'h0002,16'h0001,2'b11,4'b0001},
      // R5: zero together with carry
      '{1'b0,1'b0,1'b0,1'b0,3'd0,16'hFFFF,16'h0001,16'h0000,2'b11,4'b0011},
      '{1'b0,1'b0,1'b0,1'b0,3'd0,16'h8000,16'h7F10,16'hFF10,2'b11,4'b0100},
      // R4: positive + positive -> negative
      '{1'b0,1'b0,1'b0,1'b0,3'd0,16'h7FFF,16'h0010,16'h800F,2'b11,4'b1100},
      // R4: negative + negative -> positive, with carry
      '{1'b0,1'b0,1'b0,1'b0,3'd0,16'h8000,16'hFF00,16'h7F00,2'b11,4'b1001},
      // R6 R7: byte to register, upper src/dst bytes ignored
      '{1'b1,1'b0,1'b0,1'b0,3'd0,16'h1280,16'hAB73,16'h00F3,2'b11,4'b0100},
      '{1'b1,1'b0,1'b0,1'b0,3'd0,16'hFF7F,16'h0010,16'h008F,2'b11,4'b1100},
      '{1'b1,1'b0,1'b0,1'b0,3'd0,16'h0080,16'h5580,16'h0000,2'b11,4'b1011},
      // R8: memory low lane
      '{1'b1,1'b1,1'b0,1'b0,3'd0,16'h0044,16'hAA11,16'hAA55,2'b01,4'b0000},
      // R8: memory high lane
      '{1'b1,1'b1,1'b1,1'b0,3'd0,16'h00F0,16'h3412,16'h2412,2'b10,4'b0001},
      // R9: constants, src_operand must be ignored
      '{1'b0,1'b0,1'b0,1'b1,3'd5,16'hDEAD,16'h9999,16'h9998,2'b11,4'b0101},
      '{1'b0,1'b0,1'b0,1'b1,3'd3,16'hDEAD,16'h7777,16'h777B,2'b11,4'b0000},
      '{1'b1,1'b1,1'b1,1'b1,3'd5,16'hDEAD,16'h3355,16'h3255,2'b10,4'b0001},
      '{1'b1,1'b0,1'b0,1'b1,3'd4,16'hDEAD,16'h1288,16'h0090,2'b11,4'b0100},
      '{1'b0,1'b0,1'b0,1'b1,3'd0,16'hDEAD,16'h0000,16'h0000,2'b11,4'b0010},
      '{1'b0,1'b0,1'b0,1'b1,3'd1,16'hDEAD,16'h5555,16'h5556,2'b11,4'b0000},
      '{1'b0,1'b0,1'b0,1'b1,3'd2,16'hDEAD,16'h6666,16'h6668,2'b11,4'b0000},
      '{1'b0,1'b0,1'b0,1'b1,3'd7,16'hDEAD,16'h1234,16'h1234,2'b11,4'b0000}
   };

   task automatic check(input string req, input string what, input logic [15:0] act,
                        input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v, input logic [15:0] st);
      @(negedge clk);
      byte_mode = v.bm; dst_is_mem = v.mem; lane_hi = v.hi; src_is_const = v.kc;
      const_code = v.k; src_operand = v.src; dst_operand = v.dst; status_in = st;
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   function automatic logic [15:0] status_of(input logic [3:0] f);
      return {7'b0, f[3], 5'b0, f[2], f[1], f[0]};
   endfunction

   function automatic string tag_of(input vec_t v);
      if (v.kc) return "R9";
      if (v.bm && v.mem) return "R8";
      if (v.bm) return "R6/R7";
      return "R3/R4/R5/R11";
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      vec_t v;
      logic [15:0] es;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "sum in reset", sum_q, 16'h0);
      check("R1", "status in reset", status_q, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "wb after reset", wb_data_q, 16'h0);
      check("R1", "we/valid after reset", {13'b0, byte_we_q, res_valid}, 16'h0);

      for (int i = 0; i < NV; i++) begin
         v = TBL[i];
         apply(v, 16'h0000);
         es = v.bm ? {8'h00, (v.mem && v.hi) ? v.wb[15:8] : v.wb[7:0]} : v.wb;
         check(tag_of(v), $sformatf("wb vec %0d", i), wb_data_q, v.wb);
         check(tag_of(v), $sformatf("we vec %0d", i), {14'b0, byte_we_q}, {14'b0, v.we});
         check(tag_of(v), $sformatf("status vec %0d", i), status_q, status_of(v.fl));
         check(tag_of(v), $sformatf("sum vec %0d", i), sum_q, es);
         check("R2", $sformatf("res_valid vec %0d", i), {15'b0, res_valid}, 16'h1);
      end

      // R2: no strobe, changed inputs must not move outputs
      @(negedge clk);
      byte_mode = 1'b0; dst_is_mem = 1'b0; src_is_const = 1'b0;
      src_operand = 16'h1111; dst_operand = 16'h2222; status_in = 16'hFFFF;
      repeat (2) @(negedge clk);
      check("R2", "hold wb", wb_data_q, 16'h1234);
      check("R2", "hold status", status_q, 16'h0000);
      check("R2", "hold sum", sum_q, 16'h1234);
      check("R2", "valid low", {15'b0, res_valid}, 16'h0);

      // R10: non-flag bits copied from the incoming status word
      v = '{1'b0,1'b0,1'b0,1'b0,3'd0,16'h0001,16'h0001,16'h0002,2'b11,4'b0000};
      apply(v, 16'hFEF8);
      check("R10", "keep upper bits", status_q, 16'hFEF8);
      apply(v, 16'h0107);
      check("R10", "stale flags cleared", status_q, 16'h0000);
      v = '{1'b0,1'b0,1'b0,1'b0,3'd0,16'h7FFF,16'h0001,16'h8000,2'b11,4'b1100};
      apply(v, 16'h5A00);
      check("R10", "mix with flags", status_q, 16'h5B04);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule